// File: doc/BRIEF.md
# Clocked controller for an asynchronous 16-bit static RAM

This block lets a synchronous host read and write an external asynchronous static RAM of 64K words of 16 bits. The host hands over one access at a time on a valid/ready request channel. Each request carries a word address, write data, one enable bit per byte lane and a read/write flag. For every read the block returns a single-cycle response strobe with the read data. The memory side is a set of registered active-low strobes: chip select, write strobe, output enable and one lane enable per byte. It also drives a split data bus (drive value, drive enable, captured input) that a bidirectional pad joins together.

Every timing minimum of the memory is a parameter in picoseconds. The block turns each one into a cycle count by rounding up against the clock-period parameter. A read holds chip select and output enable low for the read count and samples the bus in the last of those cycles. A write takes one setup cycle with chip select low, then holds the write strobe low for the write count with the data driven. It then raises every strobe and releases the bus on one edge. Between accesses all strobes return high for at least one cycle.

Back-pressure rules on the request channel: `req_ready` is high only while the block is idle. A request is taken on an edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the host must hold the request unchanged. The response channel has no back-pressure: `rsp_valid` is a one-cycle pulse and the host must take it.

Top module: `sram_async_ctl`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. While it is high, chip select, write strobe and output enable are all high. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. After an accepted read, `req_ready` returns high in the cycle of its response pulse. After an accepted write, it returns high in the cycle after the write strobe rises.
- R2: A read holds chip select low and output enable low, with the write strobe high, for RD_CYC consecutive cycles. These cycles start on the edge after acceptance. Output enable is never low unless chip select is low and the write strobe is high.
- R3: A write spends one cycle with chip select low and the write strobe and output enable high. It then holds the write strobe low for WR_CYC cycles. On the edge that ends that pulse, the write strobe, chip select and lane enables all rise together. The bench's memory model stores each enabled lane at that rising edge.
- R4: Address and lane enables stay constant for as long as chip select is low. Write data stays constant while the block drives the bus. Both hold the values captured at acceptance, even if the host changes its inputs afterwards.
- R5: `mem_be_n[0]` is the active-low enable of bits 7..0 and `mem_be_n[1]` of bits 15..8. Each equals the inverse of `req_be[0]` / `req_be[1]` during the access and is high otherwise. A write with a lane disabled leaves that lane of the memory word unchanged.
- R6: A read produces `rsp_valid` for exactly one cycle, the cycle after its last output-enable cycle. `rsp_rdata` holds the bus value sampled in that last cycle. A lane whose `req_be` bit was 0 reads as zero.
- R7: A read accepted in the first idle cycle after a write adds one idle cycle before chip select falls. In that idle cycle all strobes are high and the bus is not driven. A read accepted later, or after a read, gets no extra cycle.
- R8: `mem_dq_oe` is high only during the write-strobe-low cycles of a write. It is never high while output enable is low.
- R9: RD_CYC is the largest of: ceil(address access / clock), ceil(output-enable access / clock) and ceil(read cycle / clock) - 1, and at least 1. WR_CYC is the largest of: ceil(write pulse / clock), ceil(data setup / clock) and ceil(x / clock) - 1 for each of write cycle, chip-select-to-end, address-setup-to-end and lane-enable-to-end, and at least 1. With the defaults at a 5 ns clock, both are 2.
- R10: During and right after reset, `req_ready` is 1, all memory strobes and lane enables are high, `mem_dq_oe` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = lower byte |
| mem_dq_o | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 16 | Value seen on the data bus |

## Verification
Two events can fall in the same cycle. A read's response pulse can coincide with acceptance of the next request, because the block is idle again in that cycle. A write's last strobe cycle is followed at once by acceptance of a read, which must then take the turnaround cycle. The bench provokes both by holding `req_valid` high across back-to-back requests and by issuing a read with no gap after a write. Its behavioural memory model drives the bus only under the read conditions. Each cycle the bench compares every pin against its own per-access expectation. It confirms that the response data, the acceptance cycle and the delayed output enable are all correct together.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_READ,
    S_WSET,
    S_WPULSE
  } seq_state_e;

  // Round a picosecond minimum up to whole clock cycles.
  function automatic int ceil_cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_async_timer.sv
module sram_async_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/sram_async_seq.sv
module sram_async_seq
  import sram_async_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2,
  parameter int CNT_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic act_nxt,
  output logic sample,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);

  seq_state_e st, nxt;
  logic             turn_q;
  logic             load;
  logic             last;
  logic [CNT_W-1:0] load_val;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt = st;
    unique case (st)
      S_IDLE:   if (accept) nxt = req_write ? S_WSET : (turn_q ? S_TURN : S_READ);
      S_TURN:   nxt = S_READ;
      S_READ:   if (last) nxt = S_IDLE;
      S_WSET:   nxt = S_WPULSE;
      S_WPULSE: if (last) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign load     = ((nxt == S_READ) && (st != S_READ)) ||
                    ((nxt == S_WPULSE) && (st != S_WPULSE));
  assign load_val = (nxt == S_WPULSE) ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
  assign act_nxt  = (nxt == S_READ) || (nxt == S_WSET) || (nxt == S_WPULSE);
  assign sample   = (st == S_READ) && last;

  sram_async_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (last)
  );

  // Pins are registered from the next state so they never glitch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      turn_q <= 1'b0;
      ce_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      dq_oe  <= 1'b0;
    end else begin
      st     <= nxt;
      turn_q <= (st == S_WPULSE) && last;
      ce_n   <= !act_nxt;
      oe_n   <= (nxt != S_READ);
      we_n   <= (nxt != S_WPULSE);
      dq_oe  <= (nxt == S_WPULSE);
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && we_n && oe_n));

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));

  p_write_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> ($past(we_n) && $past(we_n, 2)));

endmodule

// File: rtl/sram_async_lanes.sv
module sram_async_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LANES-1:0]        be_in,
  input  logic                    act_nxt,
  input  logic                    sample,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES-1:0]        be_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  logic [LANES-1:0] be_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      be_hold <= '0;
      rvalid  <= 1'b0;
    end else begin
      if (load) be_hold <= be_in;
      rvalid <= sample;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              en_now;
    logic              bn_q;
    logic [LANE_W-1:0] rd_q;

    assign en_now = load ? be_in[l] : be_hold[l];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bn_q <= 1'b1;
        rd_q <= '0;
      end else begin
        bn_q <= !(act_nxt && en_now);
        if (sample) rd_q <= be_hold[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
      end
    end

    assign be_n[l]                    = bn_q;
    assign rdata[l*LANE_W +: LANE_W]  = rd_q;
  end

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_async_pkg::*;
#(
  parameter int CLK_PS    = 5000,
  parameter int T_RC_PS   = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_DOE_PS  = 5000,
  parameter int T_WC_PS   = 10000,
  parameter int T_PWE_PS  = 8000,
  parameter int T_SCE_PS  = 8000,
  parameter int T_AW_PS   = 7000,
  parameter int T_SD_PS   = 5000,
  parameter int T_BW_PS   = 7000,
  parameter int AW        = 16,
  parameter int LANES     = 2,
  parameter int LANE_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic [LANES-1:0]        req_be,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [LANES-1:0]        mem_be_n,
  output logic [LANES*LANE_W-1:0] mem_dq_o,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_i
);

  localparam int DW     = LANES * LANE_W;
  localparam int RD_CYC = imax(1, imax(ceil_cyc(T_AA_PS, CLK_PS),
                          imax(ceil_cyc(T_DOE_PS, CLK_PS), ceil_cyc(T_RC_PS, CLK_PS) - 1)));
  localparam int WR_SET = imax(imax(ceil_cyc(T_WC_PS, CLK_PS), ceil_cyc(T_SCE_PS, CLK_PS)),
                          imax(ceil_cyc(T_AW_PS, CLK_PS), ceil_cyc(T_BW_PS, CLK_PS))) - 1;
  localparam int WR_CYC = imax(1, imax(imax(ceil_cyc(T_PWE_PS, CLK_PS), ceil_cyc(T_SD_PS, CLK_PS)),
                          WR_SET));
  localparam int CNT_W  = $clog2(imax(RD_CYC, WR_CYC) + 1);

  logic          accept;
  logic          act_nxt;
  logic          sample;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  sram_async_seq #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .act_nxt   (act_nxt),
    .sample    (sample),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_async_lanes #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .be_in   (req_be),
    .act_nxt (act_nxt),
    .sample  (sample),
    .dq_i    (mem_dq_i),
    .be_n    (mem_be_n),
    .rdata   (rsp_rdata),
    .rvalid  (rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  p_wdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  p_lane_in_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be_n != {LANES{1'b1}}) |-> !mem_ce_n);

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

endmodule

// File: tb/sram_async_ctl_tb.sv
`timescale 1ns/1ps
module sram_async_ctl_tb;

  localparam int RD = 2;   // R9: 10 ns access at 5 ns clock
  localparam int WR = 2;   // R9: 8 ns write pulse at 5 ns clock

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_i;

  always #2.5 clk = ~clk;

  sram_async_ctl u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n), .mem_be_n (mem_be_n), .mem_dq_o (mem_dq_o),
    .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Behavioural memory (indexed by low address byte) and host-side shadow.
  logic [15:0] pmem   [256];
  logic [15:0] shadow [256];

  always_comb begin
    mem_dq_i = 16'hEEEE;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      for (int l = 0; l < 2; l++)
        if (!mem_be_n[l]) mem_dq_i[l*8 +: 8] = pmem[mem_addr[7:0]][l*8 +: 8];
    end
  end

  typedef struct {
    bit ce_n, oe_n, we_n, dq_oe, ready, rsp;
    bit [1:0] be_n;
    logic [15:0] addr, dq, rdata;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur, prv;
  string idle_tag = "R1";

  bit          p_ce = 1, p_we = 1;
  logic [1:0]  p_be = 2'b11;
  logic [15:0] p_addr, p_dq;

  function automatic exp_t idle_exp();
    exp_t e;
    e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0; e.ready = 1; e.rsp = 0;
    e.be_n = 2'b11; e.addr = '0; e.dq = '0; e.rdata = '0; e.tag = idle_tag;
    return e;
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    prv = cur;
    cur = (q.size() > 0) ? q.pop_front() : idle_exp();
    chk("R1", "req_ready", 16'(req_ready), 16'(cur.ready));
    chk(cur.tag, "ce_n", 16'(mem_ce_n), 16'(cur.ce_n));
    chk(cur.tag, "oe_n", 16'(mem_oe_n), 16'(cur.oe_n));
    chk(cur.tag, "we_n", 16'(mem_we_n), 16'(cur.we_n));
    chk("R5", "be_n", 16'(mem_be_n), 16'(cur.be_n));
    chk("R8", "dq_oe", 16'(mem_dq_oe), 16'(cur.dq_oe));
    chk("R6", "rsp_valid", 16'(rsp_valid), 16'(cur.rsp));
    if (!cur.ce_n) chk("R4", "addr", mem_addr, cur.addr);
    if (cur.dq_oe) chk("R4", "dq_o", mem_dq_o, cur.dq);
    if (cur.rsp)   chk("R6", "rdata", rsp_rdata, cur.rdata);
    // Memory stores enabled lanes when the write strobe rises (R3).
    if (!p_ce && !p_we && mem_we_n)
      for (int l = 0; l < 2; l++)
        if (!p_be[l]) pmem[p_addr[7:0]][l*8 +: 8] = p_dq[l*8 +: 8];
    p_ce = mem_ce_n; p_we = mem_we_n; p_be = mem_be_n;
    p_addr = mem_addr; p_dq = mem_dq_o;
  endtask

  task automatic push_access(bit w, logic [15:0] a, logic [15:0] d, logic [1:0] be);
    exp_t e;
    e = idle_exp();
    e.ready = 0; e.addr = a;
    if (!w && !prv.we_n) begin   // R7: read right after write waits one cycle
      e.tag = "R7";
      q.push_back(e);
    end
    e.ce_n = 0; e.be_n = ~be;
    if (w) begin
      e.tag = "R3"; e.oe_n = 1; e.we_n = 1;
      q.push_back(e);
      e.we_n = 0; e.dq_oe = 1; e.dq = d;
      for (int k = 0; k < WR; k++) q.push_back(e);
      for (int l = 0; l < 2; l++)
        if (be[l]) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
    end else begin
      e.tag = "R2/R9"; e.oe_n = 0; e.we_n = 1;
      for (int k = 0; k < RD; k++) q.push_back(e);
      e = idle_exp();
      e.tag = "R6"; e.rsp = 1;
      for (int l = 0; l < 2; l++)
        e.rdata[l*8 +: 8] = be[l] ? shadow[a[7:0]][l*8 +: 8] : 8'h00;
      q.push_back(e);
    end
  endtask

  task automatic send(bit w, logic [15:0] a, logic [15:0] d, logic [1:0] be);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    forever begin
      if (cur.ready) begin
        push_access(w, a, d, be);
        tick();
        break;
      end
      tick();
    end
    req_valid = 0; req_addr = ~a; req_wdata = ~d; req_be = ~be; req_write = ~w;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      pmem[i]   = 16'(i * 16'h0101) ^ 16'h3C5A;
      shadow[i] = 16'(i * 16'h0101) ^ 16'h3C5A;
    end
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    idle_tag = "R10";
    cur = idle_exp(); prv = cur;
    idle(4);
    rst_n = 1;
    idle(2);
    idle_tag = "R1";

    // Full and partial lane writes, then read-backs after a gap.
    send(1, 16'h0010, 16'hA1B2, 2'b11); idle(1);
    send(0, 16'h0010, 16'h0000, 2'b11); idle(1);
    send(1, 16'h0020, 16'h1234, 2'b01); idle(2);
    send(0, 16'h0020, 16'h0000, 2'b11); idle(1);
    send(1, 16'h0030, 16'h5678, 2'b10); idle(1);
    send(0, 16'h0030, 16'h0000, 2'b11); idle(1);
    send(1, 16'h0040, 16'hFFFF, 2'b00); idle(1);
    send(0, 16'h0040, 16'h0000, 2'b11); idle(1);
    // Lane-masked reads.
    send(0, 16'h0010, 16'h0, 2'b01);
    send(0, 16'h0010, 16'h0, 2'b10);
    send(0, 16'h0010, 16'h0, 2'b00);
    // Write immediately followed by read (turnaround) and read after write with gap.
    send(1, 16'hFF55, 16'hBEEF, 2'b11);
    send(0, 16'hFF55, 16'h0, 2'b11);
    send(1, 16'h0066, 16'hC0DE, 2'b11); idle(1);
    send(0, 16'h0066, 16'h0, 2'b11);
    // Back-to-back writes then read then write.
    send(1, 16'h0070, 16'h1111, 2'b11);
    send(1, 16'h0071, 16'h2222, 2'b10);
    send(0, 16'h0071, 16'h0, 2'b11);
    send(1, 16'h0072, 16'h3333, 2'b01);
    idle(3);

    for (int n = 0; n < 400; n++) begin
      bit          w  = 1'($urandom_range(0, 1));
      logic [15:0] a  = 16'($urandom);
      logic [15:0] d  = 16'($urandom);
      logic [1:0]  be = 2'($urandom_range(0, 3));
      send(w, a, d, be);
      idle($urandom_range(0, 2));
    end
    idle(6);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule